// File: doc/BRIEF.md
# Stride Load Address Predictor

This block predicts, for each load instruction, the memory address that its next dynamic instance will access. A direct-mapped table is selected by the load's program counter. Each entry remembers the most recent address, the step between successive addresses, a 3-bit confidence counter and a 3-bit prefetch distance. The predicted address is the remembered address plus the step. A prediction is flagged usable only when the confidence counter has saturated.

When a usable prediction is produced, the block also issues a prefetch address. This address lies several instances of the same load ahead, so that a value table downstream can be filled before those instances arrive.

Each entry adjusts its own look-ahead from hit/miss feedback on that value table. A miss pushes the distance further out. A hit pulls it back in.

Training uses the real address of each load when it commits. Lookups and training can happen in the same cycle.

Top module: `stride_addr_pred`

## Requirements
- R1: While reset is low and in the cycle after reset, all outputs are 0. After reset no entry is allocated, so any lookup returns `pred_valid_o` = 0.
- R2: A lookup presented with `pred_req_i` = 1 produces its result on the outputs one clock later. When the entry's tag matches, `pred_valid_o` is 1 and `pred_addr_o` equals last address + stride. Otherwise `pred_valid_o` is 0.
- R3: The entry index is PC bits [IDX_W+1:2] and the tag is the TAG_W bits above them. A commit update whose tag does not match the stored entry reallocates it: last address = committed address, stride = 0, confidence = 0, distance = 1. The old PC then no longer hits.
- R4: A commit update on a matching entry always overwrites the last address. If (committed − last) equals the stored stride, confidence increments and saturates at 7. Otherwise confidence clears to 0 and the stride takes the new delta.
- R5: `pred_conf_o` is 1 only when the hitting entry's confidence is 7.
- R6: `pf_valid_o` pulses for one cycle with the result of a confident lookup and never otherwise. `pf_addr_o` = last + stride × (distance + 1).
- R7: Feedback (`fb_valid_i`) that names a confident entry with a matching tag changes that entry's distance. A miss (`fb_hit_i` = 0) increments it, saturating at 7. A hit decrements it, with a floor of 1. Feedback naming a tag-mismatched PC has no effect.
- R8: A lookup and a commit update to the same entry in the same cycle: the lookup returns the entry as it was before the update.
- R9: A commit update and feedback to the same entry in the same cycle: the update is applied and the feedback is dropped.
- R10: In a cycle following one with no lookup request, `pred_valid_o`, `pred_conf_o` and `pf_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_req_i | input | 1 | Lookup request |
| pred_pc_i | input | PC_W | PC of the load being predicted |
| pred_valid_o | output | 1 | Lookup hit an allocated entry with matching tag |
| pred_addr_o | output | ADDR_W | Predicted next address |
| pred_conf_o | output | 1 | Prediction is confident and usable |
| pf_valid_o | output | 1 | Prefetch request pulse |
| pf_addr_o | output | ADDR_W | Prefetch address |
| upd_valid_i | input | 1 | Load commit update |
| upd_pc_i | input | PC_W | PC of the committing load |
| upd_addr_i | input | ADDR_W | Actual address of the committing load |
| fb_valid_i | input | 1 | Value-table feedback strobe |
| fb_pc_i | input | PC_W | PC the feedback refers to |
| fb_hit_i | input | 1 | 1 = value-table hit, 0 = miss |

## Verification
A corrupted stride or last address appears on `pred_addr_o` in the cycle after the next lookup to that entry. A wrong confidence count shows up as `pred_conf_o` and `pf_valid_o` asserting one training step too early or too late in a monotone sequence. A broken distance counter is visible only through `pf_addr_o`, and only once the entry is confident. The bench therefore walks the distance across both of its limits and reads the prefetch address after each step. Tag and collision faults are exposed by aliasing two PCs onto one index, and by driving update, lookup and feedback together in one cycle.

// File: rtl/sap_pkg.sv
// Shared definitions for the stride load address predictor.
// Assumes the per-entry confidence and distance counters are both 3 bits.
package sap_pkg;
    localparam int CTR_W = 3;
    typedef logic [CTR_W-1:0] ctr_t;
    localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);
    localparam ctr_t DIST_MIN = ctr_t'(1);

    typedef enum logic [1:0] {
        TRN_ALLOC   = 2'd0,
        TRN_STEADY  = 2'd1,
        TRN_RESTEP  = 2'd2
    } trn_kind_e;

    function automatic ctr_t sat_inc(input ctr_t v);
        return (v == CTR_MAX) ? v : v + ctr_t'(1);
    endfunction

    function automatic ctr_t floor_dec(input ctr_t v);
        return (v <= DIST_MIN) ? DIST_MIN : v - ctr_t'(1);
    endfunction
endpackage

// File: rtl/sap_table.sv
// Direct-mapped predictor storage with NRD combinational read ports,
// one full-entry write port (commit training) and one distance-only
// write port (feedback). Only the valid bits are reset.
// Assumes the caller never enables both writes to the same index at once.
module sap_table
    import sap_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 8,
    parameter int NRD     = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]     rd_idx_i,
    output logic [NRD-1:0]                rd_vld_o,
    output logic [NRD-1:0][TAG_W-1:0]     rd_tag_o,
    output logic [NRD-1:0][ADDR_W-1:0]    rd_last_o,
    output logic [NRD-1:0][ADDR_W-1:0]    rd_stride_o,
    output ctr_t [NRD-1:0]                rd_conf_o,
    output ctr_t [NRD-1:0]                rd_dist_o,
    input  logic                          wr_en_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [TAG_W-1:0]              wr_tag_i,
    input  logic [ADDR_W-1:0]             wr_last_i,
    input  logic [ADDR_W-1:0]             wr_stride_i,
    input  ctr_t                          wr_conf_i,
    input  ctr_t                          wr_dist_i,
    input  logic                          dw_en_i,
    input  logic [IDX_W-1:0]              dw_idx_i,
    input  ctr_t                          dw_dist_i
);
    logic [ENTRIES-1:0]  vld_q;
    logic [TAG_W-1:0]    tag_q    [ENTRIES];
    logic [ADDR_W-1:0]   last_q   [ENTRIES];
    logic [ADDR_W-1:0]   stride_q [ENTRIES];
    ctr_t                conf_q   [ENTRIES];
    ctr_t                dist_q   [ENTRIES];

    // Read ports: one combinational view per requester.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_vld_o[p]    = vld_q[rd_idx_i[p]];
            rd_tag_o[p]    = tag_q[rd_idx_i[p]];
            rd_last_o[p]   = last_q[rd_idx_i[p]];
            rd_stride_o[p] = stride_q[rd_idx_i[p]];
            rd_conf_o[p]   = conf_q[rd_idx_i[p]];
            rd_dist_o[p]   = dist_q[rd_idx_i[p]];
        end
    end

    // Valid bits: cleared by reset, set on any training write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i] <= 1'b1;
        end
    end

    // Entry payload: full write from training, distance write from feedback.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_q[wr_idx_i]    <= wr_tag_i;
            last_q[wr_idx_i]   <= wr_last_i;
            stride_q[wr_idx_i] <= wr_stride_i;
            conf_q[wr_idx_i]   <= wr_conf_i;
            dist_q[wr_idx_i]   <= wr_dist_i;
        end
        if (dw_en_i) begin
            dist_q[dw_idx_i] <= dw_dist_i;
        end
    end
endmodule

// File: rtl/sap_train.sv
// Next-state computation for one entry on a load commit.
// Assumes 'hit' already combines the entry valid bit with the tag compare.
module sap_train
    import sap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit_i,
    input  logic [ADDR_W-1:0] act_addr_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  ctr_t              conf_i,
    input  ctr_t              dist_i,
    output logic [ADDR_W-1:0] last_o,
    output logic [ADDR_W-1:0] stride_o,
    output ctr_t              conf_o,
    output ctr_t              dist_o
);
    logic [ADDR_W-1:0] delta;
    trn_kind_e         kind;

    // Classify the commit: fresh allocation, stride confirmed, or new stride.
    always_comb begin
        delta = act_addr_i - last_i;
        if (!hit_i)                kind = TRN_ALLOC;
        else if (delta == stride_i) kind = TRN_STEADY;
        else                        kind = TRN_RESTEP;
    end

    // Produce the new entry fields for the chosen case.
    always_comb begin
        last_o = act_addr_i;
        unique case (kind)
            TRN_ALLOC: begin
                stride_o = '0;
                conf_o   = '0;
                dist_o   = DIST_MIN;
            end
            TRN_STEADY: begin
                stride_o = stride_i;
                conf_o   = sat_inc(conf_i);
                dist_o   = dist_i;
            end
            default: begin
                stride_o = delta;
                conf_o   = '0;
                dist_o   = dist_i;
            end
        endcase
    end
endmodule

// File: rtl/sap_predict.sv
// Combinational prediction from one looked-up entry: next address,
// confidence flag and the look-ahead prefetch address.
// Assumes 'hit' already combines the entry valid bit with the tag compare.
module sap_predict
    import sap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  ctr_t              conf_i,
    input  ctr_t              dist_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              conf_o,
    output logic [ADDR_W-1:0] pf_addr_o
);
    logic [ADDR_W-1:0] steps;

    // Address of the next instance and of the instance 'dist' beyond it.
    always_comb begin
        steps     = ADDR_W'(dist_i) + ADDR_W'(1);
        valid_o   = hit_i;
        addr_o    = last_i + stride_i;
        conf_o    = hit_i && (conf_i == CTR_MAX);
        pf_addr_o = last_i + stride_i * steps;
    end
endmodule

// File: rtl/stride_addr_pred.sv
// Stride load address predictor top. Port 0 of the table serves lookups,
// port 1 commit training, port 2 value-table feedback. Outputs are
// registered: a lookup's result appears one clock after the request.
// Assumes PCs are word aligned (bits [1:0] ignored) and PC_W covers
// index plus tag bits.
module stride_addr_pred
    import sap_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_req_i,
    input  logic [PC_W-1:0]   pred_pc_i,
    output logic              pred_valid_o,
    output logic [ADDR_W-1:0] pred_addr_o,
    output logic              pred_conf_o,
    output logic              pf_valid_o,
    output logic [ADDR_W-1:0] pf_addr_o,
    input  logic              upd_valid_i,
    input  logic [PC_W-1:0]   upd_pc_i,
    input  logic [ADDR_W-1:0] upd_addr_i,
    input  logic              fb_valid_i,
    input  logic [PC_W-1:0]   fb_pc_i,
    input  logic              fb_hit_i
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int NRD   = 3;
    localparam int P_PRD = 0;
    localparam int P_UPD = 1;
    localparam int P_FB  = 2;

    logic [NRD-1:0][PC_W-1:0]   pc_of;
    logic [NRD-1:0][IDX_W-1:0]  idx;
    logic [NRD-1:0][TAG_W-1:0]  tag;
    logic [NRD-1:0]             rd_vld;
    logic [NRD-1:0][TAG_W-1:0]  rd_tag;
    logic [NRD-1:0][ADDR_W-1:0] rd_last;
    logic [NRD-1:0][ADDR_W-1:0] rd_stride;
    ctr_t [NRD-1:0]             rd_conf;
    ctr_t [NRD-1:0]             rd_dist;
    logic [NRD-1:0]             hit;

    // Route each requester's PC to its table port.
    always_comb begin
        pc_of[P_PRD] = pred_pc_i;
        pc_of[P_UPD] = upd_pc_i;
        pc_of[P_FB]  = fb_pc_i;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_port
        // Split the PC into index and tag, and compare the tag.
        always_comb begin
            idx[p] = pc_of[p][IDX_W+1:2];
            tag[p] = pc_of[p][IDX_W+2 +: TAG_W];
            hit[p] = rd_vld[p] && (rd_tag[p] == tag[p]);
        end
    end

    logic [ADDR_W-1:0] w_last, w_stride;
    ctr_t              w_conf, w_dist;
    logic              fb_apply;
    ctr_t              fb_dist;

    sap_train #(.ADDR_W(ADDR_W)) u_train (
        .hit_i      (hit[P_UPD]),
        .act_addr_i (upd_addr_i),
        .last_i     (rd_last[P_UPD]),
        .stride_i   (rd_stride[P_UPD]),
        .conf_i     (rd_conf[P_UPD]),
        .dist_i     (rd_dist[P_UPD]),
        .last_o     (w_last),
        .stride_o   (w_stride),
        .conf_o     (w_conf),
        .dist_o     (w_dist)
    );

    // Feedback adjusts distance of confident matching entries unless a
    // commit to the same index wins this cycle.
    always_comb begin
        fb_apply = fb_valid_i && hit[P_FB] && (rd_conf[P_FB] == CTR_MAX)
                   && !(upd_valid_i && (idx[P_UPD] == idx[P_FB]));
        fb_dist  = fb_hit_i ? floor_dec(rd_dist[P_FB]) : sat_inc(rd_dist[P_FB]);
    end

    sap_table #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .TAG_W   (TAG_W),
        .NRD     (NRD)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_i    (idx),
        .rd_vld_o    (rd_vld),
        .rd_tag_o    (rd_tag),
        .rd_last_o   (rd_last),
        .rd_stride_o (rd_stride),
        .rd_conf_o   (rd_conf),
        .rd_dist_o   (rd_dist),
        .wr_en_i     (upd_valid_i),
        .wr_idx_i    (idx[P_UPD]),
        .wr_tag_i    (tag[P_UPD]),
        .wr_last_i   (w_last),
        .wr_stride_i (w_stride),
        .wr_conf_i   (w_conf),
        .wr_dist_i   (w_dist),
        .dw_en_i     (fb_apply),
        .dw_idx_i    (idx[P_FB]),
        .dw_dist_i   (fb_dist)
    );

    logic              p_valid, p_conf;
    logic [ADDR_W-1:0] p_addr, p_pf_addr;

    sap_predict #(.ADDR_W(ADDR_W)) u_predict (
        .hit_i     (hit[P_PRD]),
        .last_i    (rd_last[P_PRD]),
        .stride_i  (rd_stride[P_PRD]),
        .conf_i    (rd_conf[P_PRD]),
        .dist_i    (rd_dist[P_PRD]),
        .valid_o   (p_valid),
        .addr_o    (p_addr),
        .conf_o    (p_conf),
        .pf_addr_o (p_pf_addr)
    );

    // Register lookup results; flags drop in cycles without a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid_o <= 1'b0;
            pred_conf_o  <= 1'b0;
            pf_valid_o   <= 1'b0;
            pred_addr_o  <= '0;
            pf_addr_o    <= '0;
        end else begin
            pred_valid_o <= pred_req_i && p_valid;
            pred_conf_o  <= pred_req_i && p_conf;
            pf_valid_o   <= pred_req_i && p_conf;
            pred_addr_o  <= (pred_req_i && p_valid) ? p_addr : '0;
            pf_addr_o    <= (pred_req_i && p_conf) ? p_pf_addr : '0;
        end
    end
endmodule

// File: rtl/sap_checker.sv
// Port-level properties of the stride load address predictor.
// Assumes it is bound to every instance of stride_addr_pred.
module sap_checker (
    input logic clk,
    input logic rst_n,
    input logic pred_req_i,
    input logic pred_valid_o,
    input logic pred_conf_o,
    input logic pf_valid_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!pred_valid_o && !pred_conf_o && !pf_valid_o)); // R1

    AST_CONF_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pred_conf_o |-> pred_valid_o); // R5

    AST_PF_ONLY_CONFIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> (pred_conf_o && pred_valid_o)); // R6

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req_i |=> (!pred_valid_o && !pf_valid_o && !pred_conf_o)); // R10
endmodule

bind stride_addr_pred sap_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pred_req_i   (pred_req_i),
    .pred_valid_o (pred_valid_o),
    .pred_conf_o  (pred_conf_o),
    .pf_valid_o   (pf_valid_o)
);

// File: tb/stride_addr_pred_tb.sv
// Directed bench for stride_addr_pred: one task per scenario.
module stride_addr_pred_tb;
    localparam int PC_W = 32;
    localparam int AW   = 32;
    localparam logic [31:0] PC_A = 32'h0000_1000; // index 0, tag 2
    localparam logic [31:0] PC_B = 32'h0000_1800; // index 0, tag 3
    localparam logic [31:0] PC_C = 32'h0000_2004; // index 1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_req_i = 1'b0;
    logic [PC_W-1:0] pred_pc_i = '0;
    logic pred_valid_o, pred_conf_o, pf_valid_o;
    logic [AW-1:0] pred_addr_o, pf_addr_o;
    logic upd_valid_i = 1'b0;
    logic [PC_W-1:0] upd_pc_i = '0;
    logic [AW-1:0] upd_addr_i = '0;
    logic fb_valid_i = 1'b0;
    logic [PC_W-1:0] fb_pc_i = '0;
    logic fb_hit_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    stride_addr_pred u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_req_i(pred_req_i), .pred_pc_i(pred_pc_i),
        .pred_valid_o(pred_valid_o), .pred_addr_o(pred_addr_o),
        .pred_conf_o(pred_conf_o), .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_addr_i(upd_addr_i),
        .fb_valid_i(fb_valid_i), .fb_pc_i(fb_pc_i), .fb_hit_i(fb_hit_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Lookup then sample the registered result at the following negedge.
    task automatic lookup(input logic [31:0] pc);
        @(negedge clk);
        pred_req_i = 1'b1; pred_pc_i = pc;
        @(negedge clk);
        pred_req_i = 1'b0;
    endtask

    task automatic expect_pred(input string req, input logic v, input logic [31:0] a,
                               input logic c, input logic [31:0] pf);
        chk(req, "pred_valid", 32'(pred_valid_o), 32'(v));
        if (v) chk(req, "pred_addr", pred_addr_o, a);
        chk(req, "pred_conf", 32'(pred_conf_o), 32'(c));
        chk(req, "pf_valid", 32'(pf_valid_o), 32'(c));
        if (c) chk(req, "pf_addr", pf_addr_o, pf);
    endtask

    task automatic commit(input logic [31:0] pc, input logic [31:0] a);
        @(negedge clk);
        upd_valid_i = 1'b1; upd_pc_i = pc; upd_addr_i = a;
        @(negedge clk);
        upd_valid_i = 1'b0;
    endtask

    task automatic feedback(input logic [31:0] pc, input logic h);
        @(negedge clk);
        fb_valid_i = 1'b1; fb_pc_i = pc; fb_hit_i = h;
        @(negedge clk);
        fb_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pred_valid in reset", 32'(pred_valid_o), 0);
        chk("R1", "pf_valid in reset", 32'(pf_valid_o), 0);
        @(negedge clk); rst_n = 1'b1;
        lookup(PC_A);
        expect_pred("R1", 1'b0, 0, 1'b0, 0);
    endtask

    task automatic t_alloc();
        commit(PC_A, 100);
        lookup(PC_A);
        expect_pred("R3", 1'b1, 100, 1'b0, 0);
        lookup(PC_C);
        expect_pred("R2", 1'b0, 0, 1'b0, 0);
    endtask

    task automatic t_train();
        for (int k = 1; k <= 7; k++) commit(PC_A, 32'(100 + 4 * k));
        lookup(PC_A);
        expect_pred("R5", 1'b1, 132, 1'b0, 0); // confidence 6
        commit(PC_A, 132);
        lookup(PC_A);
        expect_pred("R6", 1'b1, 136, 1'b1, 140); // confidence 7, distance 1
        @(negedge clk);
        chk("R10", "pred_valid idle", 32'(pred_valid_o), 0);
        chk("R10", "pf_valid idle", 32'(pf_valid_o), 0);
    endtask

    task automatic t_feedback();
        feedback(PC_A, 1'b0);
        lookup(PC_A);
        expect_pred("R7", 1'b1, 136, 1'b1, 144); // distance 2
        for (int k = 0; k < 8; k++) feedback(PC_A, 1'b0);
        lookup(PC_A);
        expect_pred("R7", 1'b1, 136, 1'b1, 164); // saturates at 7
        for (int k = 0; k < 10; k++) feedback(PC_A, 1'b1);
        lookup(PC_A);
        expect_pred("R7", 1'b1, 136, 1'b1, 140); // floor at 1
        feedback(PC_B, 1'b0);
        lookup(PC_A);
        expect_pred("R7", 1'b1, 136, 1'b1, 140); // alias feedback ignored
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid_i = 1'b1; upd_pc_i = PC_A; upd_addr_i = 136;
        pred_req_i = 1'b1; pred_pc_i = PC_A;
        @(negedge clk);
        upd_valid_i = 1'b0; pred_req_i = 1'b0;
        expect_pred("R8", 1'b1, 136, 1'b1, 140);
        lookup(PC_A);
        expect_pred("R8", 1'b1, 140, 1'b1, 144);
    endtask

    task automatic t_fb_conflict();
        @(negedge clk);
        upd_valid_i = 1'b1; upd_pc_i = PC_A; upd_addr_i = 140;
        fb_valid_i = 1'b1; fb_pc_i = PC_A; fb_hit_i = 1'b0;
        @(negedge clk);
        upd_valid_i = 1'b0; fb_valid_i = 1'b0;
        lookup(PC_A);
        expect_pred("R9", 1'b1, 144, 1'b1, 148);
    endtask

    task automatic t_restep();
        commit(PC_A, 200);
        lookup(PC_A);
        expect_pred("R4", 1'b1, 260, 1'b0, 0);
        commit(PC_A, 260);
        lookup(PC_A);
        expect_pred("R4", 1'b1, 320, 1'b0, 0); // confidence 1
    endtask

    task automatic t_alias();
        commit(PC_B, 500);
        lookup(PC_A);
        expect_pred("R3", 1'b0, 0, 1'b0, 0);
        lookup(PC_B);
        expect_pred("R3", 1'b1, 500, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_alloc();
        t_train();
        t_feedback();
        t_same_cycle();
        t_fb_conflict();
        t_restep();
        t_alias();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule